// File: doc/BRIEF.md
# Paired-Access General Register File

This block is a general register file of 128 words, each 32 bits wide. It sits beside a separate file of 32 single-bit predicates. Any port can read or write one 32-bit word. It can also treat an even-odd pair of words as one 64-bit value, where the even word holds bits 31:0 and the odd word holds bits 63:32. The block has two read ports and one write port, and each port carries its own size flag.

The predicate file takes the one-bit results of compare and condition operations through a dedicated predicate write port. Any predicate can be read back. A register write may name a predicate as its guard, and the write then lands only if that predicate holds 1. A 64-bit access that names an odd register raises an alignment error on its own port. Reads are combinational from the stored state, and writes take effect at the rising clock edge. The block has no forwarding, no hazard logic and no arbitration between issuers.

Top module: `paired_regfile`

## Requirements
- R1: An active-low reset clears all 128 registers and all 32 predicates to 0.
- R2: A narrow access (size flag 0) writes wr_data[31:0] into the named register. A narrow read returns that register in data[31:0] with data[63:32] equal to 0.
- R3: A wide access (size flag 1) with an even index n writes wr_data[31:0] to register n and wr_data[63:32] to register n+1. A wide read returns {reg[n+1], reg[n]}.
- R4: A wide access whose index has bit 0 set raises the misalign flag of that port in the same cycle. A misaligned read returns all zeros, and a misaligned write changes no register.
- R5: When wr_guard_en is 1, a write commits only if predicate wr_guard_idx is 1. When wr_guard_en is 0, the write commits unconditionally.
- R6: A predicate write stores pw_val into predicate pw_idx at the clock edge, and pr_val shows predicate pr_idx. A write guard reads the predicate value from before any predicate update at that same edge.
- R7: A read of a register in the same cycle as a write to it returns the old value. The new value appears after the edge.
- R8: The two read ports work independently: each has its own index, size flag, data and misalign flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 7 | Read port A register index |
| rd_a_wide | input | 1 | Read port A size: 1 = 64-bit pair |
| rd_a_data | output | 64 | Read port A data |
| rd_a_misalign | output | 1 | Read port A odd index on a wide read |
| rd_b_idx | input | 7 | Read port B register index |
| rd_b_wide | input | 1 | Read port B size: 1 = 64-bit pair |
| rd_b_data | output | 64 | Read port B data |
| rd_b_misalign | output | 1 | Read port B odd index on a wide read |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 7 | Write register index |
| wr_wide | input | 1 | Write size: 1 = 64-bit pair |
| wr_data | input | 64 | Write data |
| wr_guard_en | input | 1 | Write is guarded by a predicate |
| wr_guard_idx | input | 5 | Guarding predicate index |
| wr_misalign | output | 1 | Write port odd index on a wide write |
| pw_en | input | 1 | Predicate write request |
| pw_idx | input | 5 | Predicate write index |
| pw_val | input | 1 | Predicate value (compare result) |
| pr_idx | input | 5 | Predicate read index |
| pr_val | output | 1 | Predicate read value |

## Verification
The bench checks the word order of pairs at both ends of the file. A design that swapped the halves, or wrote a wide value into one word only, would return the wrong 64-bit value or the wrong narrow word. It checks that a narrow read keeps the upper half at zero, and that a misaligned wide write leaves both neighbouring words untouched. A design that rounded the odd index down would corrupt the pair below. It also checks a guarded write on the edge where the guard predicate itself is cleared. A design that used the new predicate value would drop that write. Finally, it checks a read and a write of the same register in one cycle, where a bypassing design would return the new value too early.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int unsigned GPR_COUNT  = 128;
    localparam int unsigned WORD_BITS  = 32;
    localparam int unsigned PRED_COUNT = 32;

    typedef enum logic {
        SIZE_NARROW = 1'b0,
        SIZE_WIDE   = 1'b1
    } acc_size_e;
endpackage

// File: rtl/rf_gpr_bank.sv
module rf_gpr_bank #(
    parameter int unsigned NREG = regfile_pkg::GPR_COUNT,
    parameter int unsigned XLEN = regfile_pkg::WORD_BITS,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IW-1:0]       widx,
    input  logic                wwide,
    input  logic [2*XLEN-1:0]   wdata,
    output logic [XLEN-1:0]     regs_o [NREG]
);
    logic [IW-1:0] even_idx, odd_idx;

    always_comb begin
        even_idx = {widx[IW-1:1], 1'b0};
        odd_idx  = {widx[IW-1:1], 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREG); i++) begin
                regs_o[i] <= '0;
            end
        end else if (we) begin
            if (wwide) begin
                regs_o[even_idx] <= wdata[XLEN-1:0];
                regs_o[odd_idx]  <= wdata[2*XLEN-1:XLEN];
            end else begin
                regs_o[widx] <= wdata[XLEN-1:0];
            end
        end
    end

    // R4
    aligned_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wwide) |-> !widx[0]);

    // R3
    wide_high_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wwide) |=> regs_o[$past(odd_idx)] == $past(wdata[2*XLEN-1:XLEN]));
endmodule

// File: rtl/rf_pred_bank.sv
module rf_pred_bank #(
    parameter int unsigned NPRED = regfile_pkg::PRED_COUNT,
    localparam int unsigned PW   = $clog2(NPRED)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pw_en,
    input  logic [PW-1:0]    pw_idx,
    input  logic             pw_val,
    output logic [NPRED-1:0] bits_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_o <= '0;
        end else if (pw_en) begin
            bits_o[pw_idx] <= pw_val;
        end
    end

    // R1
    pred_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (bits_o == '0));

    // R6
    pred_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_en |=> bits_o[$past(pw_idx)] == $past(pw_val));
endmodule

// File: rtl/rf_write_gate.sv
module rf_write_gate (
    input  logic wr_en,
    input  logic wide,
    input  logic idx_lsb,
    input  logic guard_en,
    input  logic guard_bit,
    output logic misalign,
    output logic commit
);
    always_comb begin
        misalign = wide & idx_lsb;
        commit   = wr_en & ~misalign & (~guard_en | guard_bit);
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int unsigned NREG = regfile_pkg::GPR_COUNT,
    parameter int unsigned XLEN = regfile_pkg::WORD_BITS,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic [XLEN-1:0]   regs [NREG],
    input  logic [IW-1:0]     idx,
    input  logic              wide,
    output logic [2*XLEN-1:0] data,
    output logic              misalign
);
    import regfile_pkg::*;

    acc_size_e size;

    always_comb begin
        size     = acc_size_e'(wide);
        misalign = (size == SIZE_WIDE) && idx[0];
        data     = '0;
        if (!misalign) begin
            unique case (size)
                SIZE_WIDE:   data = {regs[{idx[IW-1:1], 1'b1}], regs[{idx[IW-1:1], 1'b0}]};
                SIZE_NARROW: data[XLEN-1:0] = regs[idx];
                default:     data = '0;
            endcase
        end
    end
endmodule

// File: rtl/paired_regfile.sv
module paired_regfile #(
    parameter int unsigned NREG  = regfile_pkg::GPR_COUNT,
    parameter int unsigned XLEN  = regfile_pkg::WORD_BITS,
    parameter int unsigned NPRED = regfile_pkg::PRED_COUNT,
    localparam int unsigned IW   = $clog2(NREG),
    localparam int unsigned PW   = $clog2(NPRED),
    localparam int unsigned DW   = 2 * XLEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_a_idx,
    input  logic          rd_a_wide,
    output logic [DW-1:0] rd_a_data,
    output logic          rd_a_misalign,
    input  logic [IW-1:0] rd_b_idx,
    input  logic          rd_b_wide,
    output logic [DW-1:0] rd_b_data,
    output logic          rd_b_misalign,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_wide,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_guard_en,
    input  logic [PW-1:0] wr_guard_idx,
    output logic          wr_misalign,
    input  logic          pw_en,
    input  logic [PW-1:0] pw_idx,
    input  logic          pw_val,
    input  logic [PW-1:0] pr_idx,
    output logic          pr_val
);
    logic [XLEN-1:0]  regs [NREG];
    logic [NPRED-1:0] pred_bits;
    logic             commit;
    logic             guard_bit;

    assign guard_bit = pred_bits[wr_guard_idx];
    assign pr_val    = pred_bits[pr_idx];

    rf_write_gate u_gate (
        .wr_en     (wr_en),
        .wide      (wr_wide),
        .idx_lsb   (wr_idx[0]),
        .guard_en  (wr_guard_en),
        .guard_bit (guard_bit),
        .misalign  (wr_misalign),
        .commit    (commit)
    );

    rf_gpr_bank #(.NREG(NREG), .XLEN(XLEN)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (commit),
        .widx   (wr_idx),
        .wwide  (wr_wide),
        .wdata  (wr_data),
        .regs_o (regs)
    );

    rf_pred_bank #(.NPRED(NPRED)) u_pred (
        .clk    (clk),
        .rst_n  (rst_n),
        .pw_en  (pw_en),
        .pw_idx (pw_idx),
        .pw_val (pw_val),
        .bits_o (pred_bits)
    );

    rf_read_port #(.NREG(NREG), .XLEN(XLEN)) u_rd_a (
        .regs     (regs),
        .idx      (rd_a_idx),
        .wide     (rd_a_wide),
        .data     (rd_a_data),
        .misalign (rd_a_misalign)
    );

    rf_read_port #(.NREG(NREG), .XLEN(XLEN)) u_rd_b (
        .regs     (regs),
        .idx      (rd_b_idx),
        .wide     (rd_b_wide),
        .data     (rd_b_data),
        .misalign (rd_b_misalign)
    );

    // R5
    guard_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_guard_en && !pred_bits[wr_guard_idx]) |-> !commit);

    // R2
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a_wide |-> (rd_a_data[DW-1:XLEN] == '0));

    // R4
    misalign_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_misalign |-> (rd_b_data == '0));
endmodule

// File: tb/tb_paired_regfile.sv
module tb_paired_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic        rd_a_wide, rd_b_wide, wr_wide;
    logic [63:0] rd_a_data, rd_b_data, wr_data;
    logic        rd_a_misalign, rd_b_misalign, wr_misalign;
    logic        wr_en, wr_guard_en;
    logic [4:0]  wr_guard_idx, pw_idx, pr_idx;
    logic        pw_en, pw_val, pr_val;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    paired_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_wide(rd_a_wide), .rd_a_data(rd_a_data), .rd_a_misalign(rd_a_misalign),
        .rd_b_idx(rd_b_idx), .rd_b_wide(rd_b_wide), .rd_b_data(rd_b_data), .rd_b_misalign(rd_b_misalign),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_wide(wr_wide), .wr_data(wr_data),
        .wr_guard_en(wr_guard_en), .wr_guard_idx(wr_guard_idx), .wr_misalign(wr_misalign),
        .pw_en(pw_en), .pw_idx(pw_idx), .pw_val(pw_val), .pr_idx(pr_idx), .pr_val(pr_val)
    );

    // {wr_idx[7], wr_wide, wr_data[64], rd_idx[7], rd_wide, expected[64]}
    localparam logic [143:0] VEC [NV] = '{
        {7'd5,   1'b0, 64'h11111111_DEADBEEF, 7'd5,   1'b0, 64'h00000000_DEADBEEF}, // R2
        {7'd10,  1'b1, 64'h01234567_89ABCDEF, 7'd10,  1'b1, 64'h01234567_89ABCDEF}, // R3
        {7'd20,  1'b0, 64'h00000000_00000005, 7'd11,  1'b0, 64'h00000000_01234567}, // R3
        {7'd12,  1'b0, 64'h00000000_AAAA5555, 7'd12,  1'b1, 64'h00000000_AAAA5555}, // R3
        {7'd126, 1'b1, 64'hFFFFFFFF_00000001, 7'd127, 1'b0, 64'h00000000_FFFFFFFF}, // R3
        {7'd0,   1'b0, 64'h00000000_00000001, 7'd0,   1'b1, 64'h00000000_00000001}, // R2
        {7'd11,  1'b0, 64'h00000000_00000077, 7'd10,  1'b1, 64'h00000077_89ABCDEF}, // R3
        {7'd127, 1'b0, 64'h00000000_0000CAFE, 7'd126, 1'b1, 64'h0000CAFE_00000001}  // R3
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_idx = '0; wr_wide = 1'b0; wr_data = '0;
        wr_guard_en = 1'b0; wr_guard_idx = '0;
        pw_en = 1'b0; pw_idx = '0; pw_val = 1'b0;
    endtask

    // Called at a negedge; applies a write across one rising edge, returns at the next negedge.
    task automatic do_write(input logic [6:0] idx, input logic wide, input logic [63:0] d,
                            input logic gen, input logic [4:0] gidx);
        wr_en = 1'b1; wr_idx = idx; wr_wide = wide; wr_data = d;
        wr_guard_en = gen; wr_guard_idx = gidx;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic read_a(input logic [6:0] idx, input logic wide);
        rd_a_idx = idx; rd_a_wide = wide;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        if (!finished) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        rd_a_idx = '0; rd_a_wide = 1'b0; rd_b_idx = '0; rd_b_wide = 1'b0; pr_idx = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        begin
            logic [63:0] acc = '0;
            logic pacc = 1'b0;
            for (int i = 0; i < 128; i++) begin
                read_a(7'(i), 1'b0);
                acc |= rd_a_data;
            end
            for (int i = 0; i < 32; i++) begin
                pr_idx = 5'(i);
                #1;
                pacc |= pr_val;
            end
            check("R1 regs after reset", acc, 64'h0);
            check("R1 preds after reset", {63'h0, pacc}, 64'h0);
        end
        @(negedge clk);

        // Table walk: write, then read on both ports after the edge
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][143:137], VEC[v][136], VEC[v][135:72], 1'b0, 5'd0);
            rd_b_idx = VEC[v][71:65]; rd_b_wide = VEC[v][64];
            read_a(VEC[v][71:65], VEC[v][64]);
            check($sformatf("R2/R3 vector %0d port A", v), rd_a_data, VEC[v][63:0]);
            check($sformatf("R8 vector %0d port B", v), rd_b_data, VEC[v][63:0]);
        end

        // R7: same-cycle read sees the old value, new value after edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 7'd5; wr_wide = 1'b0; wr_data = 64'h0_12345678;
        read_a(7'd5, 1'b0);
        check("R7 old value in write cycle", rd_a_data, 64'h0_DEADBEEF);
        @(negedge clk);
        idle_inputs();
        read_a(7'd5, 1'b0);
        check("R7 new value after edge", rd_a_data, 64'h0_12345678);

        // R4: misaligned wide write is flagged and suppressed
        wr_en = 1'b1; wr_idx = 7'd3; wr_wide = 1'b1; wr_data = '1;
        #1;
        check("R4 write misalign flag", {63'h0, wr_misalign}, 64'h1);
        @(negedge clk);
        idle_inputs();
        read_a(7'd2, 1'b1);
        check("R4 pair 2/3 untouched", rd_a_data, 64'h0);
        read_a(7'd4, 1'b0);
        check("R4 reg 4 untouched", rd_a_data, 64'h0);

        // R4 / R8: misaligned read on A, aligned wide read on B in the same cycle
        rd_b_idx = 7'd10; rd_b_wide = 1'b1;
        read_a(7'd11, 1'b1);
        check("R4 read misalign flag", {63'h0, rd_a_misalign}, 64'h1);
        check("R4 misaligned read data", rd_a_data, 64'h0);
        check("R8 port B independent flag", {63'h0, rd_b_misalign}, 64'h0);
        check("R8 port B independent data", rd_b_data, 64'h00000077_89ABCDEF);

        // R5: guard predicate 4 is 0, write dropped
        do_write(7'd30, 1'b0, 64'h99, 1'b1, 5'd4);
        read_a(7'd30, 1'b0);
        check("R5 guarded write dropped", rd_a_data, 64'h0);

        // R6: set predicate 4
        pw_en = 1'b1; pw_idx = 5'd4; pw_val = 1'b1;
        @(negedge clk);
        idle_inputs();
        pr_idx = 5'd4; #1;
        check("R6 predicate set", {63'h0, pr_val}, 64'h1);

        // R5: guard true, write lands
        do_write(7'd30, 1'b0, 64'h99, 1'b1, 5'd4);
        read_a(7'd30, 1'b0);
        check("R5 guarded write commits", rd_a_data, 64'h99);

        // R6: guard uses predicate value from before the same-edge clear
        pw_en = 1'b1; pw_idx = 5'd4; pw_val = 1'b0;
        do_write(7'd31, 1'b0, 64'h42, 1'b1, 5'd4);
        read_a(7'd31, 1'b0);
        check("R6 guard reads old predicate", rd_a_data, 64'h42);
        pr_idx = 5'd4; #1;
        check("R6 predicate cleared", {63'h0, pr_val}, 64'h0);

        // R1: reset mid-run
        pw_en = 1'b1; pw_idx = 5'd7; pw_val = 1'b1;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_a(7'd10, 1'b1);
        check("R1 pair 10 cleared by reset", rd_a_data, 64'h0);
        read_a(7'd127, 1'b0);
        check("R1 reg 127 cleared by reset", rd_a_data, 64'h0);
        pr_idx = 5'd7; #1;
        check("R1 predicate 7 cleared by reset", {63'h0, pr_val}, 64'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule